// File: doc/BRIEF.md
# Open-Page DRAM Block Fetch Sequencer

This block turns a single cache-block read request into the DRAM command stream needed to fetch that block, under an open-page policy. It remembers, for every bank, whether a row is open and which one. From that record each new request falls into one of three classes. A row-hit goes straight to the reads. A row-closed request first opens the row. A row-conflict first closes the old row and then opens the new one. The class sets both the command order and the total latency.

A block is fetched with a fixed train of burst reads, spaced so that their data bursts follow one another without a gap. The sequencer raises a data-valid window while block data is on the bus and pulses a done strobe once the last beat has passed. It accepts one request at a time and signals readiness only while idle. Latency counts run from the cycle of the first command to the last data beat, inclusive. With the default timing of 5 cycles each for precharge, activate-to-read and CAS, a hit takes 21 cycles, a closed row 26 and a conflict 31.

Top module: `dram_blk_fetch_seq`

## Requirements
- R1: After reset every bank counts as closed, all command strobes, `rd_data_valid` and `blk_done` are low, and `req_ready` is high. A reset in the middle of a fetch also leaves every bank closed.
- R2: A request to a bank with no open row produces an activate in the cycle after acceptance, with `cmd_addr` equal to the row. The first read follows T_RCD (5) cycles after the activate, and no precharge is issued.
- R3: A request whose row matches the row open in its bank issues its first read in the cycle after acceptance, with no precharge and no activate.
- R4: A request to a bank holding a different open row issues a precharge to that bank in the cycle after acceptance. An activate of the new row follows T_RP (5) cycles later, and the first read T_RCD cycles after that.
- R5: Every block is fetched with exactly 4 reads to the requested bank, 4 cycles apart. Read i (i = 0..3) carries the column `{req_col[9:5], i[1:0], 3'b000}`, so the low 5 bits of `req_col` are ignored.
- R6: `rd_data_valid` rises T_CL (5) cycles after the first read and stays high for exactly 16 consecutive cycles.
- R7: `blk_done` is a one-cycle pulse in the cycle after the last data beat. The span from first command to last beat is 21 cycles for a hit, 26 for a closed row and 31 for a conflict.
- R8: `req_ready` is low from the cycle after acceptance through the done cycle, and high again in the cycle after `blk_done`. A `req_valid` raised while busy is ignored: it causes no commands and does not change the open-row record.
- R9: Row state is kept per bank. Opening a row in one bank does not alter the open row of any other bank.
- R10: At most one of `cmd_pre`, `cmd_act` and `cmd_rd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Block fetch request, taken when `req_ready` is high |
| req_bank | input | 3 | Bank of the block |
| req_row | input | 14 | Row of the block |
| req_col | input | 10 | Column of the block; low 5 bits ignored |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_act | output | 1 | Activate strobe |
| cmd_rd | output | 1 | Read strobe |
| cmd_bank | output | 3 | Bank for the current command |
| cmd_addr | output | 14 | Row for activate, column for read, zero for precharge |
| rd_data_valid | output | 1 | Block data is on the bus |
| blk_done | output | 1 | One-cycle pulse after the final data beat |

## Verification
The hardest case to reach from the ports is the row-conflict. It needs a bank already left open on one row by an earlier fetch, and then a request to another row of that same bank. There is a second hard case. The record of another bank must survive in between, and a request made while busy must not corrupt it. The stimulus table therefore chains requests through banks 0, 3 and 7: a row opens, another bank is touched, the first bank is hit again, and then a different row is hit in it. A directed test raises a request mid-fetch and then shows, through a following row-hit, that the record was left alone.

// File: rtl/dfs_pkg.sv
// Shared types of the block fetch sequencer.
// Assumes: nothing beyond the standard language.
package dfs_pkg;

    // Class of a request relative to the open row of its bank
    typedef enum logic [1:0] {
        ACC_CLOSED   = 2'd0,
        ACC_HIT      = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_kind_e;

    // Command sequencer states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RP_WAIT  = 3'd1,
        ST_RCD_WAIT = 3'd2,
        ST_READ     = 3'd3,
        ST_DRAIN    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dfs_row_tracker.sv
// Per-bank open-row record with combinational lookup.
// Keeps an open flag and a row number for each bank. An update marks a
// bank open on a row; nothing closes a bank except reset, because a
// precharge here is always followed by an activate of the new row.
// Assumes: lk_bank and upd_bank are below NUM_BANKS.
module dfs_row_tracker
    import dfs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int BANK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output acc_kind_e         lk_kind,
    input  logic              upd_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);

    logic             open_q [NUM_BANKS];
    logic [ROW_W-1:0] row_q  [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Record the row opened in this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (upd_en && upd_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= upd_row;
            end
        end
    end

    // Classify the looked-up request against its bank's record
    always_comb begin
        if (!open_q[lk_bank])
            lk_kind = ACC_CLOSED;
        else if (row_q[lk_bank] == lk_row)
            lk_kind = ACC_HIT;
        else
            lk_kind = ACC_CONFLICT;
    end

endmodule

// File: rtl/dfs_cmd_fsm.sv
// Command sequencer for one block fetch.
// On acceptance it issues precharge/activate as the access class demands,
// waits T_RP / T_RCD with a down-counter, then issues N_READS reads spaced
// RD_GAP cycles apart. It holds busy until the data window reports done.
// All command outputs are registered and appear the cycle after decision.
// Assumes: N_READS >= 2, all timing parameters >= 1.
module dfs_cmd_fsm
    import dfs_pkg::*;
#(
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int ADDR_W    = 14,
    parameter int T_RP      = 5,
    parameter int T_RCD     = 5,
    parameter int N_READS   = 4,
    parameter int BURST_LEN = 8,
    parameter int RD_GAP    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  acc_kind_e         lk_kind,
    input  logic              blk_done,
    output logic              req_ready,
    output logic              cmd_pre,
    output logic              cmd_act,
    output logic              cmd_rd,
    output logic              cmd_last_rd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam int IDX_W    = $clog2(N_READS);
    localparam int BURST_W  = $clog2(BURST_LEN);
    localparam int BLK_LSB  = IDX_W + BURST_W;
    localparam int MAX_WAIT = (T_RP > T_RCD) ? ((T_RP > RD_GAP) ? T_RP : RD_GAP)
                                             : ((T_RCD > RD_GAP) ? T_RCD : RD_GAP);
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [COL_W-1:0] LOW_MASK = COL_W'((1 << BLK_LSB) - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  wait_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  colbase_q;

    // Column of read number idx within a block based at base
    function automatic logic [ADDR_W-1:0] rd_col(input logic [COL_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
        logic [COL_W-1:0] c;
        c = base | (COL_W'(idx) << BURST_W);
        return ADDR_W'(c);
    endfunction

    assign req_ready = (state_q == ST_IDLE);

    // Advance the sequence and drive registered command strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wait_q      <= '0;
            idx_q       <= '0;
            row_q       <= '0;
            colbase_q   <= '0;
            cmd_pre     <= 1'b0;
            cmd_act     <= 1'b0;
            cmd_rd      <= 1'b0;
            cmd_last_rd <= 1'b0;
            cmd_bank    <= '0;
            cmd_addr    <= '0;
        end else begin
            cmd_pre     <= 1'b0;
            cmd_act     <= 1'b0;
            cmd_rd      <= 1'b0;
            cmd_last_rd <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        row_q     <= req_row;
                        colbase_q <= req_col & ~LOW_MASK;
                        cmd_bank  <= req_bank;
                        unique case (lk_kind)
                            ACC_CONFLICT: begin
                                cmd_pre  <= 1'b1;
                                cmd_addr <= '0;
                                wait_q   <= CNT_W'(T_RP - 1);
                                state_q  <= ST_RP_WAIT;
                            end
                            ACC_CLOSED: begin
                                cmd_act  <= 1'b1;
                                cmd_addr <= ADDR_W'(req_row);
                                wait_q   <= CNT_W'(T_RCD - 1);
                                state_q  <= ST_RCD_WAIT;
                            end
                            default: begin
                                cmd_rd   <= 1'b1;
                                cmd_addr <= rd_col(req_col & ~LOW_MASK, '0);
                                idx_q    <= IDX_W'(1);
                                wait_q   <= CNT_W'(RD_GAP - 1);
                                state_q  <= ST_READ;
                            end
                        endcase
                    end
                end
                ST_RP_WAIT: begin
                    if (wait_q == '0) begin
                        cmd_act  <= 1'b1;
                        cmd_addr <= ADDR_W'(row_q);
                        wait_q   <= CNT_W'(T_RCD - 1);
                        state_q  <= ST_RCD_WAIT;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_RCD_WAIT: begin
                    if (wait_q == '0) begin
                        cmd_rd   <= 1'b1;
                        cmd_addr <= rd_col(colbase_q, '0);
                        idx_q    <= IDX_W'(1);
                        wait_q   <= CNT_W'(RD_GAP - 1);
                        state_q  <= ST_READ;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_READ: begin
                    if (wait_q == '0) begin
                        cmd_rd   <= 1'b1;
                        cmd_addr <= rd_col(colbase_q, idx_q);
                        if (idx_q == IDX_W'(N_READS - 1)) begin
                            cmd_last_rd <= 1'b1;
                            state_q     <= ST_DRAIN;
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            wait_q <= CNT_W'(RD_GAP - 1);
                        end
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (blk_done)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dfs_data_window.sv
// Data-valid window and done strobe generator.
// Delays each read strobe by T_CL cycles; each delayed read opens a burst
// of BURST_CYC valid cycles. The done pulse follows the final beat of the
// burst belonging to the read flagged last.
// Assumes: T_CL >= 2, BURST_CYC >= 2, reads no closer than BURST_CYC.
module dfs_data_window #(
    parameter int T_CL      = 5,
    parameter int BURST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    input  logic rd_last,
    output logic data_valid,
    output logic done
);

    localparam int BEAT_W = $clog2(BURST_CYC + 1);

    logic [T_CL-1:0]   rd_pipe_q;
    logic [T_CL-1:0]   last_pipe_q;
    logic [BEAT_W-1:0] beat_q;
    logic              last_q;
    logic              arrive;

    assign arrive     = rd_pipe_q[T_CL-1];
    assign data_valid = arrive || (beat_q != '0);

    // Delay read strobes by the CAS latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe_q   <= '0;
            last_pipe_q <= '0;
        end else begin
            rd_pipe_q   <= {rd_pipe_q[T_CL-2:0], rd_issue};
            last_pipe_q <= {last_pipe_q[T_CL-2:0], rd_issue && rd_last};
        end
    end

    // Count remaining beats of the current burst and flag the block end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            last_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (arrive)
                beat_q <= BEAT_W'(BURST_CYC - 1);
            else if (beat_q != '0)
                beat_q <= beat_q - 1'b1;
            done <= (beat_q == BEAT_W'(1)) && last_q;
            if (arrive && last_pipe_q[T_CL-1])
                last_q <= 1'b1;
            else if ((beat_q == BEAT_W'(1)) && last_q)
                last_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dram_blk_fetch_seq.sv
// Open-page DRAM block fetch sequencer (top).
// Classifies a block read against the per-bank open-row record, issues
// the matching precharge/activate/read sequence and reports the data
// window and completion. The row record is updated from the issued
// activate strobe.
// Assumes: one request in flight; widths derived from parameters.
module dram_blk_fetch_seq
    import dfs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int T_RP      = 5,
    parameter int T_RCD     = 5,
    parameter int T_CL      = 5,
    parameter int N_READS   = 4,
    parameter int BURST_LEN = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic              cmd_pre,
    output logic              cmd_act,
    output logic              cmd_rd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_data_valid,
    output logic              blk_done
);

    localparam int RD_GAP = BURST_LEN / 2;

    acc_kind_e lk_kind;
    logic      cmd_last_rd;

    dfs_row_tracker #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) tracker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (req_bank),
        .lk_row   (req_row),
        .lk_kind  (lk_kind),
        .upd_en   (cmd_act),
        .upd_bank (cmd_bank),
        .upd_row  (cmd_addr[ROW_W-1:0])
    );

    dfs_cmd_fsm #(
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .ADDR_W    (ADDR_W),
        .T_RP      (T_RP),
        .T_RCD     (T_RCD),
        .N_READS   (N_READS),
        .BURST_LEN (BURST_LEN),
        .RD_GAP    (RD_GAP)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_col     (req_col),
        .lk_kind     (lk_kind),
        .blk_done    (blk_done),
        .req_ready   (req_ready),
        .cmd_pre     (cmd_pre),
        .cmd_act     (cmd_act),
        .cmd_rd      (cmd_rd),
        .cmd_last_rd (cmd_last_rd),
        .cmd_bank    (cmd_bank),
        .cmd_addr    (cmd_addr)
    );

    dfs_data_window #(
        .T_CL      (T_CL),
        .BURST_CYC (RD_GAP)
    ) window_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (cmd_rd),
        .rd_last    (cmd_last_rd),
        .data_valid (rd_data_valid),
        .done       (blk_done)
    );

endmodule

// File: rtl/dfs_seq_checker.sv
// Protocol checker for the block fetch sequencer, bound to the top.
// Measures command spacing and window length with local counters.
// Assumes: the same timing parameters as the bound instance.
module dfs_seq_checker #(
    parameter int T_RP      = 5,
    parameter int T_RCD     = 5,
    parameter int N_READS   = 4,
    parameter int BURST_LEN = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic cmd_pre,
    input logic cmd_act,
    input logic cmd_rd,
    input logic rd_data_valid,
    input logic blk_done
);

    localparam int RD_GAP  = BURST_LEN / 2;
    localparam int BLK_CYC = N_READS * RD_GAP;

    logic [7:0] gap_q;
    logic       prev_pre_q, prev_act_q;
    logic [7:0] rd_cnt_q;
    logic [7:0] run_q;

    // Track spacing since the previous command and its type
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= 8'hFF;
            prev_pre_q <= 1'b0;
            prev_act_q <= 1'b0;
        end else if (cmd_pre || cmd_act || cmd_rd) begin
            gap_q      <= 8'd1;
            prev_pre_q <= cmd_pre;
            prev_act_q <= cmd_act;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // Count reads per block and length of the current valid run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
            run_q    <= '0;
        end else begin
            if (blk_done)
                rd_cnt_q <= '0;
            else if (cmd_rd)
                rd_cnt_q <= rd_cnt_q + 8'd1;
            run_q <= rd_data_valid ? run_q + 8'd1 : 8'd0;
        end
    end

    assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre, cmd_act, cmd_rd}));

    assert_rp_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && prev_pre_q) |-> (gap_q == 8'(T_RP)));

    assert_rcd_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && prev_act_q) |-> (gap_q == 8'(T_RCD)));

    assert_rd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && rd_cnt_q != 8'd0) |-> (gap_q == 8'(RD_GAP)));

    assert_rd_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (rd_cnt_q == 8'(N_READS)));

    assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (run_q == 8'(BLK_CYC)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    assert_done_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> !rd_data_valid);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pre || cmd_act || cmd_rd || rd_data_valid || blk_done) |-> !req_ready);

endmodule

bind dram_blk_fetch_seq dfs_seq_checker #(
    .T_RP      (T_RP),
    .T_RCD     (T_RCD),
    .N_READS   (N_READS),
    .BURST_LEN (BURST_LEN)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .cmd_pre       (cmd_pre),
    .cmd_act       (cmd_act),
    .cmd_rd        (cmd_rd),
    .rd_data_valid (rd_data_valid),
    .blk_done      (blk_done)
);

// File: tb/dram_blk_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module dram_blk_fetch_seq_tb_top;

    localparam int K_CLOSED = 0;
    localparam int K_HIT    = 1;
    localparam int K_CONF   = 2;
    localparam int WIN      = 40;

    localparam int NV = 9;
    localparam int VB [NV] = '{0, 0, 0, 3, 0, 3, 7, 7, 0};
    localparam int VR [NV] = '{10, 10, 11, 11, 11, 200, 16383, 16383, 10};
    localparam int VC [NV] = '{'h040, 'h3E5, 'h120, 'h01F, 'h3FF, 'h000, 'h000, 'h2A1, 'h060};
    localparam int VK [NV] = '{K_CLOSED, K_HIT, K_CONF, K_CLOSED, K_HIT, K_CONF, K_CLOSED, K_HIT, K_CONF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [13:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready, cmd_pre, cmd_act, cmd_rd, rd_data_valid, blk_done;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dram_blk_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
        .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .rd_data_valid(rd_data_valid), .blk_done(blk_done)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Capture of one fetch
    int pre_cyc, pre_n, pre_bank, act_cyc, act_n, act_row, act_bank;
    int rd_n, multi_n, dv_first, dv_last, dv_n, done_cyc, done_n;
    int rd_cyc [8];
    int rd_col [8];
    int rd_bank [8];
    bit rdy [WIN+1];

    // Drive one request, capture WIN cycles, check against the class
    task automatic run_req(input int b, input int r, input int c, input int k,
                           input string tag, input int intr);
        int rd0, lat, colb;
        pre_cyc = -1; pre_n = 0; pre_bank = -1; act_cyc = -1; act_n = 0;
        act_row = -1; act_bank = -1; rd_n = 0; multi_n = 0; dv_first = -1;
        dv_last = -1; dv_n = 0; done_cyc = -1; done_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_bank = 3'(b); req_row = 14'(r); req_col = 10'(c);
        @(negedge clk);
        for (int k2 = 1; k2 <= WIN; k2++) begin
            req_valid = (k2 == intr);
            req_row   = 14'(r + 1);
            rdy[k2] = req_ready;
            if ((int'(cmd_pre) + int'(cmd_act) + int'(cmd_rd)) > 1) multi_n++;
            if (cmd_pre) begin pre_n++; pre_cyc = k2; pre_bank = cmd_bank; end
            if (cmd_act) begin act_n++; act_cyc = k2; act_row = cmd_addr; act_bank = cmd_bank; end
            if (cmd_rd) begin
                if (rd_n < 8) begin
                    rd_cyc[rd_n] = k2; rd_col[rd_n] = cmd_addr; rd_bank[rd_n] = cmd_bank;
                end
                rd_n++;
            end
            if (rd_data_valid) begin
                dv_n++; if (dv_first < 0) dv_first = k2; dv_last = k2;
            end
            if (blk_done) begin done_n++; done_cyc = k2; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        rd0 = (k == K_HIT) ? 1 : (k == K_CLOSED) ? 6 : 11;
        lat = (k == K_HIT) ? 21 : (k == K_CLOSED) ? 26 : 31;
        colb = c & ~31;
        if (k == K_CONF) begin
            chk({"R4 ", tag}, "precharge count", pre_n, 1);
            chk({"R4 ", tag}, "precharge cycle", pre_cyc, 1);
            chk({"R4 ", tag}, "precharge bank", pre_bank, b);
            chk({"R4 ", tag}, "activate cycle", act_cyc, 6);
        end else if (k == K_CLOSED) begin
            chk({"R2 ", tag}, "precharge count", pre_n, 0);
            chk({"R2 ", tag}, "activate cycle", act_cyc, 1);
        end else begin
            chk({"R3 ", tag}, "precharge count", pre_n, 0);
            chk({"R3 ", tag}, "activate count", act_n, 0);
        end
        if (k != K_HIT) begin
            chk({"R2 ", tag}, "activate count", act_n, 1);
            chk({"R2 ", tag}, "activate row", act_row, r);
            chk({"R9 ", tag}, "activate bank", act_bank, b);
        end
        chk({"R5 ", tag}, "read count", rd_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk({"R5 ", tag}, "read cycle", rd_cyc[i], rd0 + 4 * i);
            chk({"R5 ", tag}, "read column", rd_col[i], colb | (i << 3));
            chk({"R5 ", tag}, "read bank", rd_bank[i], b);
        end
        chk({"R6 ", tag}, "data start", dv_first, rd0 + 5);
        chk({"R6 ", tag}, "data cycles", dv_n, 16);
        chk({"R6 ", tag}, "data span", dv_last - dv_first + 1, 16);
        chk({"R7 ", tag}, "done count", done_n, 1);
        chk({"R7 ", tag}, "latency", done_cyc - 1, lat);
        chk({"R8 ", tag}, "ready low after accept", int'(rdy[1]), 0);
        chk({"R8 ", tag}, "ready low at done", int'(rdy[done_cyc < 1 ? 1 : done_cyc]), 0);
        chk({"R8 ", tag}, "ready after done", int'(rdy[(done_cyc < 1 || done_cyc >= WIN) ? WIN : done_cyc + 1]), 1);
        chk({"R10 ", tag}, "cycles with two strobes", multi_n, 0);
    endtask

    task automatic chk_quiet(input string rq);
        chk(rq, "ready", int'(req_ready), 1);
        chk(rq, "strobes", int'(cmd_pre) + int'(cmd_act) + int'(cmd_rd), 0);
        chk(rq, "data valid", int'(rd_data_valid), 0);
        chk(rq, "done", int'(blk_done), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL all watchdog: got %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state out of reset
        chk_quiet("R1 reset");

        // Table walk: classes chained across banks 0, 3, 7 (R9 via vec3/vec4)
        for (int v = 0; v < NV; v++)
            run_req(VB[v], VR[v], VC[v], VK[v], $sformatf("vec%0d", v), 0);

        // R8: request raised while busy is ignored and leaves record intact
        run_req(1, 5, 'h100, K_CLOSED, "busy_intrude", 3);
        run_req(1, 5, 'h100, K_HIT, "after_intrude_R8", 0);

        // R1: reset in mid-fetch leaves all banks closed
        @(negedge clk);
        req_valid = 1'b1; req_bank = 3'd1; req_row = 14'd9; req_col = '0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R1 mid reset");
        run_req(1, 5, 'h100, K_CLOSED, "post_reset_R1", 0);
        run_req(0, 11, 'h000, K_CLOSED, "post_reset_bank0_R1", 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule